// File: doc/BRIEF.md
# Synchronous Burst SRAM Front-End

This block is the control and storage core of a flow-through synchronous burst SRAM with byte-lane writes. Every control input is sampled on the rising clock edge. These are three chip selects, a processor address strobe, a controller address strobe, a burst-advance strobe, a write-all strobe, a byte-write enable and one select per 8-bit lane. On an address-strobe edge the block loads a new address and samples the chip selects. On the edges that follow, it either keeps that address or steps its two low bits through a four-word burst.

Reads are flow-through. After an edge, the word at the address that edge registered appears on `rdata`. The output-enable input gates the qualifier `rdata_vld` without waiting for a clock. That qualifier stands in for the tri-state control of a shared data bus. A high `nap` input freezes all state and keeps memory contents intact. The burst order, linear or interleaved, is fixed by a parameter.

Top module: `bsram_fe`

## Requirements
- R1: The device is selected only if a load cycle sees `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A deselected device keeps `rdata_vld` low and writes nothing until a load cycle reselects it.
- R2: The chip selects are sampled only on load cycles, meaning either address strobe is recognised. On other cycles the previous selection is kept, whatever the select pins carry.
- R3: `strobe_cpu_n` low is ignored while `cs_a_n` is high. With `strobe_ctl_n` high, such a cycle loads nothing and keeps the address and the selection.
- R4: `wr_all_n` low writes all lanes of the addressed word, regardless of `wr_byte_n` and `lane_sel_n`.
- R5: With `wr_all_n` high and `wr_byte_n` low, each lane whose `lane_sel_n[i]` bit is 0 is written. Lane i is `wdata[8i+7:8i]`. With both write strobes high the cycle is a read, and `lane_sel_n` has no effect.
- R6: After each rising edge, `rdata` shows the word at the address that edge registered. A load cycle from either strobe registers `addr`.
- R7: The first read cycle after a load that moves the device from deselected to selected keeps `rdata_vld` low even with `out_en_n` low. The next read cycle is not masked.
- R8: `rdata_vld` is low whenever `out_en_n` is high, and after any write cycle.
- R9: While `nap` is high, no edge changes address, selection or memory, and `rdata_vld` is low. It stays low after `nap` falls until the next rising edge.
- R10: `burst_next_n` low on a non-load cycle steps to burst position k+1 within the four-word group. The address is base+k mod 4 when `LINEAR_BURST`=1 and base XOR k when it is 0. The bits above the low two never change. With `burst_next_n` high the address holds.
- R11: While `rst_n` is low the device is deselected and `rdata_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all control is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| nap | input | 1 | Sleep; freezes state and forces the output quiet |
| cs_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| cs_b | input | 1 | Chip select B, active high |
| cs_c_n | input | 1 | Chip select C, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, has priority |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| burst_next_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | DATA_W/8 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, acts without the clock |
| addr | input | ADDR_W | Word address, loaded on strobe cycles |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Flow-through read data |
| rdata_vld | output | 1 | High when the data bus would be driven |

## Verification
The state most likely to go wrong is the selection flag. If it is sampled on continue cycles or missed on a load, `rdata_vld` takes the wrong value one edge after the offending cycle. A deselected write that goes through shows up as wrong data at the first selected read of that word. A broken output mask opens or closes `rdata_vld` on exactly one cycle after a reselect. A burst counter that steps wrongly shows the wrong word on the edge right after the advance. The bench has two instances, one per burst order, so a swapped order is seen as soon as a burst starts from an odd position. A nap that lets state through is seen on the first read after wake-up.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   localparam int LANE_W = 8;
   localparam int BURST_W = 2;

   // linear order: positions count upward from the loaded base, wrapping in the group
   function automatic logic [BURST_W-1:0] pos_linear(input logic [BURST_W-1:0] base,
                                                     input logic [BURST_W-1:0] step);
      return base + step;
   endfunction

   // interleaved order: step bits toggle the loaded base
   function automatic logic [BURST_W-1:0] pos_interleave(input logic [BURST_W-1:0] base,
                                                         input logic [BURST_W-1:0] step);
      return base ^ step;
   endfunction

endpackage

// File: rtl/bsram_lane_dec.sv
module bsram_lane_dec #(
   parameter int LANES = 4
) (
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lanes
);

   generate
      if (LANES < 1) begin : g_bad
         $error("bsram_lane_dec: LANES must be at least 1");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         // write-all wins over the per-lane selects
         assign lanes[g] = ~wr_all_n | (~wr_byte_n & ~lane_sel_n[g]);
      end
   endgenerate

endmodule

// File: rtl/bsram_burst.sv
module bsram_burst import bsram_pkg::*; #(
   parameter int ADDR_W       = 8,
   parameter bit LINEAR_BURST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              load,
   input  logic              adv,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic [ADDR_W-1:0] cur_addr
);

   localparam int HI_W = ADDR_W - BURST_W;

   logic [HI_W-1:0]    hi_q, hi_n;
   logic [BURST_W-1:0] base_q, base_n, step_q, step_n;
   logic [BURST_W-1:0] pos_q, pos_n;

   always_comb begin
      hi_n   = load ? addr_in[ADDR_W-1:BURST_W] : hi_q;
      base_n = load ? addr_in[BURST_W-1:0] : base_q;
      if (load)     step_n = '0;
      else if (adv) step_n = step_q + 1'b1;
      else          step_n = step_q;
   end

   generate
      if (ADDR_W <= BURST_W) begin : g_bad
         $error("bsram_burst: ADDR_W must exceed the burst field");
      end
      if (LINEAR_BURST) begin : g_lin
         assign pos_n = pos_linear(base_n, step_n);
         assign pos_q = pos_linear(base_q, step_q);
      end else begin : g_ilv
         assign pos_n = pos_interleave(base_n, step_n);
         assign pos_q = pos_interleave(base_q, step_q);
      end
   endgenerate

   assign nxt_addr = {hi_n, pos_n};
   assign cur_addr = {hi_q, pos_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         base_q <= '0;
         step_q <= '0;
      end else if (!hold) begin
         hi_q   <= hi_n;
         base_q <= base_n;
         step_q <= step_n;
      end
   end

   AST_BURST_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !hold) |=> $stable(cur_addr[ADDR_W-1:BURST_W])); // R10

   AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv && !hold) |=> $stable(cur_addr)); // R10

endmodule

// File: rtl/bsram_store.sv
module bsram_store import bsram_pkg::*; #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic [DATA_W/LANE_W-1:0] we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [DATA_W-1:0]        rdata
);

   localparam int LANES = DATA_W / LANE_W;
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad
         $error("bsram_store: DATA_W must be a multiple of the lane width");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] cells [DEPTH];
         always_ff @(posedge clk) begin
            if (we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
         end
         assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
      end
   endgenerate

endmodule

// File: rtl/bsram_fe.sv
module bsram_fe import bsram_pkg::*; #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter bit LINEAR_BURST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     nap,
   input  logic                     cs_a_n,
   input  logic                     cs_b,
   input  logic                     cs_c_n,
   input  logic                     strobe_cpu_n,
   input  logic                     strobe_ctl_n,
   input  logic                     burst_next_n,
   input  logic                     wr_all_n,
   input  logic                     wr_byte_n,
   input  logic [DATA_W/LANE_W-1:0] lane_sel_n,
   input  logic                     out_en_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   output logic                     rdata_vld
);

   localparam int LANES = DATA_W / LANE_W;

   generate
      if (ADDR_W < 3 || ADDR_W > 12) begin : g_bad_addr
         $error("bsram_fe: ADDR_W out of range 3..12");
      end
      if (DATA_W < LANE_W) begin : g_bad_data
         $error("bsram_fe: DATA_W below one lane");
      end
   endgenerate

   logic             cpu_load, load, cs_ok, sel_nxt;
   logic             sel_q, rd_q, mask_q, wake_q;
   logic [LANES-1:0] lanes, we;
   logic [ADDR_W-1:0] waddr, raddr;

   // processor strobe needs select A low; it takes priority over the controller strobe
   assign cpu_load = ~strobe_cpu_n & ~cs_a_n;
   assign load     = cpu_load | ~strobe_ctl_n;
   assign cs_ok    = ~cs_a_n & cs_b & ~cs_c_n;
   assign sel_nxt  = load ? cs_ok : sel_q;

   bsram_lane_dec #(.LANES(LANES)) u_dec (
      .wr_all_n   (wr_all_n),
      .wr_byte_n  (wr_byte_n),
      .lane_sel_n (lane_sel_n),
      .lanes      (lanes)
   );

   assign we = lanes & {LANES{sel_nxt & ~nap}};

   bsram_burst #(.ADDR_W(ADDR_W), .LINEAR_BURST(LINEAR_BURST)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (nap),
      .load     (load),
      .adv      (~burst_next_n),
      .addr_in  (addr),
      .nxt_addr (waddr),
      .cur_addr (raddr)
   );

   bsram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         rd_q   <= 1'b0;
         mask_q <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         wake_q <= nap;
         if (!nap) begin
            sel_q  <= sel_nxt;
            rd_q   <= ~(|lanes);
            mask_q <= load & cs_ok & ~sel_q;
         end
      end
   end

   assign rdata_vld = sel_q & rd_q & ~mask_q & ~out_en_n & ~nap & ~wake_q;

   AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !nap) |=> $stable(sel_q)); // R2

   AST_CPU_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_cpu_n && cs_a_n && strobe_ctl_n && burst_next_n && !nap)
      |=> ($stable(raddr) && $stable(sel_q))); // R3

   AST_WR_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_all_n && sel_nxt && !nap) |-> (&we)); // R4

   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((|we) && !nap) |=> !rdata_vld); // R8

   AST_MASK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && !nap) |=> !mask_q); // R7

   AST_NAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      nap |=> ($stable(raddr) && $stable(sel_q))); // R9

   AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!nap && $past(nap)) |-> !rdata_vld); // R9

   AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !cs_ok) |-> (we == '0)); // R1

endmodule

// File: tb/bsram_fe_bench.sv
module bsram_fe_bench;

   localparam int AW = 8;
   localparam int DW = 32;
   localparam int NV = 25;
   localparam int VW = 13 + AW + DW + 1 + DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nap = 1'b0;
   logic          cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
   logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, burst_next_n = 1'b1;
   logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
   logic [3:0]    lane_sel_n = 4'hF;
   logic          out_en_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata, rdata_i;
   logic          rdata_vld, rdata_vld_i;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   bsram_fe #(.ADDR_W(AW), .DATA_W(DW), .LINEAR_BURST(1'b1)) u_bsram_fe (
      .clk(clk), .rst_n(rst_n), .nap(nap), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
      .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .burst_next_n(burst_next_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
   );

   bsram_fe #(.ADDR_W(AW), .DATA_W(DW), .LINEAR_BURST(1'b0)) u_bsram_fe_ilv (
      .clk(clk), .rst_n(rst_n), .nap(nap), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
      .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .burst_next_n(burst_next_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
      .addr(addr), .wdata(wdata), .rdata(rdata_i), .rdata_vld(rdata_vld_i)
   );

   // control field, msb first: cs_a_n cs_b cs_c_n | strobe_cpu_n strobe_ctl_n | burst_next_n
   // | wr_all_n | wr_byte_n | lane_sel_n[3:0] | out_en_n ; then addr, wdata, exp vld, exp data
   localparam logic [VW-1:0] VEC [NV] = '{
      {13'b010_10_1_0_1_1111_1, 8'h10, 32'hAABBCCDD, 1'b0, 32'h0},
      {13'b101_11_0_0_1_1111_1, 8'h00, 32'h11223344, 1'b0, 32'h0},
      {13'b010_11_0_0_1_1111_1, 8'h00, 32'h01020304, 1'b0, 32'h0},
      {13'b010_11_0_0_1_1111_1, 8'h00, 32'h0A0B0C0D, 1'b0, 32'h0},
      {13'b010_10_1_1_0_1010_1, 8'h12, 32'hF0E0D0C0, 1'b0, 32'h0},
      {13'b010_11_1_1_1_1111_0, 8'h00, 32'h0,        1'b1, 32'h01E003C0},
      {13'b010_11_1_1_1_0000_0, 8'h00, 32'hFFFFFFFF, 1'b1, 32'h01E003C0},
      {13'b010_11_1_0_1_1111_0, 8'h00, 32'hFFFF0000, 1'b0, 32'h0},
      {13'b010_11_1_1_1_1111_0, 8'h00, 32'h0,        1'b1, 32'hFFFF0000},
      {13'b010_01_1_1_1_1111_0, 8'h12, 32'h0,        1'b1, 32'hFFFF0000},
      {13'b010_11_0_1_1_1111_0, 8'h00, 32'h0,        1'b1, 32'h0A0B0C0D},
      {13'b010_11_0_1_1_1111_0, 8'h00, 32'h0,        1'b1, 32'hAABBCCDD},
      {13'b010_11_0_1_1_1111_0, 8'h00, 32'h0,        1'b1, 32'h11223344},
      {13'b010_11_1_1_1_1111_0, 8'h00, 32'h0,        1'b1, 32'h11223344},
      {13'b010_11_1_1_1_1111_1, 8'h00, 32'h0,        1'b0, 32'h0},
      {13'b110_01_1_1_1_1111_0, 8'h00, 32'h0,        1'b1, 32'h11223344},
      {13'b000_10_1_1_1_1111_0, 8'h10, 32'h0,        1'b0, 32'h0},
      {13'b010_11_1_1_1_1111_0, 8'h00, 32'h0,        1'b0, 32'h0},
      {13'b010_10_1_1_1_1111_0, 8'h10, 32'h0,        1'b0, 32'h0},
      {13'b010_11_1_1_1_1111_0, 8'h00, 32'h0,        1'b1, 32'hAABBCCDD},
      {13'b011_10_1_1_1_1111_0, 8'h10, 32'h0,        1'b0, 32'h0},
      {13'b010_11_1_0_1_1111_0, 8'h00, 32'h12345678, 1'b0, 32'h0},
      {13'b000_01_1_1_1_1111_0, 8'h10, 32'h0,        1'b0, 32'h0},
      {13'b010_10_1_1_1_1111_0, 8'h10, 32'h0,        1'b0, 32'h0},
      {13'b010_11_1_1_1_1111_0, 8'h00, 32'h0,        1'b1, 32'hAABBCCDD}
   };

   localparam string TAG [NV] = '{
      "R4", "R2", "R4", "R10", "R8", "R5", "R5", "R8", "R4", "R6",
      "R10", "R10", "R10", "R10", "R8", "R3", "R1", "R2", "R7", "R7",
      "R1", "R1", "R1", "R7", "R1"
   };

   task automatic apply(input logic [12:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
      cs_a_n       = c[12];
      cs_b         = c[11];
      cs_c_n       = c[10];
      strobe_cpu_n = c[9];
      strobe_ctl_n = c[8];
      burst_next_n = c[7];
      wr_all_n     = c[6];
      wr_byte_n    = c[5];
      lane_sel_n   = c[4:1];
      out_en_n     = c[0];
      addr         = a;
      wdata        = d;
   endtask

   task automatic chk(input string tag, input logic vld, input logic [DW-1:0] dat,
                      input logic ev, input logic [DW-1:0] ed);
      checks++;
      if (vld !== ev || (ev && dat !== ed)) begin
         errors++;
         $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h", tag, vld, dat, ev, ed);
      end
   endtask

   task automatic step(input logic [12:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      apply(c, a, d);
      @(posedge clk);
      #2;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish (all requirements)");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R11: reset holds both instances deselected and quiet
      apply(13'b010_10_1_1_1_1111_0, 8'h10, 32'h0);
      repeat (3) @(posedge clk);
      #2;
      chk("R11 reset", rdata_vld, rdata, 1'b0, 32'h0);
      chk("R11 reset ilv", rdata_vld_i, rdata_i, 1'b0, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      apply(13'b010_11_1_1_1_1111_1, 8'h00, 32'h0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][VW-1 -: 13], VEC[i][VW-14 -: AW], VEC[i][VW-14-AW -: DW]);
         chk(TAG[i], rdata_vld, rdata, VEC[i][DW], VEC[i][DW-1:0]);
      end

      // R9: nap freezes everything; a load plus write-all during nap must be lost
      @(negedge clk);
      nap = 1'b1;
      #1;
      chk("R9 nap quiet", rdata_vld, rdata, 1'b0, 32'h0);
      apply(13'b010_10_1_0_1_1111_0, 8'h13, 32'h55555555);
      @(posedge clk);
      #2;
      chk("R9 nap edge", rdata_vld, rdata, 1'b0, 32'h0);
      @(negedge clk);
      nap = 1'b0;
      apply(13'b010_11_1_1_1_1111_0, 8'h00, 32'h0);
      #1;
      chk("R9 wake quiet", rdata_vld, rdata, 1'b0, 32'h0);
      @(posedge clk);
      #2;
      chk("R9 address kept", rdata_vld, rdata, 1'b1, 32'hAABBCCDD);
      step(13'b010_10_1_1_1_1111_0, 8'h13, 32'h0);
      chk("R9 contents kept", rdata_vld, rdata, 1'b1, 32'h0A0B0C0D);

      // R10: burst from odd base, linear 1,2,3,0 versus interleaved 1,0,3,2
      step(13'b010_01_1_1_1_1111_0, 8'h11, 32'h0);
      chk("R6 load lin", rdata_vld, rdata, 1'b1, 32'h11223344);
      chk("R6 load ilv", rdata_vld_i, rdata_i, 1'b1, 32'h11223344);
      step(13'b010_11_0_1_1_1111_0, 8'h00, 32'h0);
      chk("R10 lin k1", rdata_vld, rdata, 1'b1, 32'hFFFF0000);
      chk("R10 ilv k1", rdata_vld_i, rdata_i, 1'b1, 32'hAABBCCDD);
      step(13'b010_11_0_1_1_1111_0, 8'h00, 32'h0);
      chk("R10 lin k2", rdata_vld, rdata, 1'b1, 32'h0A0B0C0D);
      chk("R10 ilv k2", rdata_vld_i, rdata_i, 1'b1, 32'h0A0B0C0D);
      step(13'b010_11_0_1_1_1111_0, 8'h00, 32'h0);
      chk("R10 lin k3", rdata_vld, rdata, 1'b1, 32'hAABBCCDD);
      chk("R10 ilv k3", rdata_vld_i, rdata_i, 1'b1, 32'hFFFF0000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule